// File: doc/BRIEF.md
# Frame-Lane Word Aligner for a Multi-Lane Serial ADC Link

This block sits behind the bit capture of a high-speed ADC link. The link has one frame lane and several data lanes. Each lane has already been captured at double data rate and geared down by four, so it delivers four bits per fabric clock. The block does not use the frame lane as a clock. It samples that lane like any data lane and uses it to find where each byte starts. Every lane keeps a short bit history. On every second fabric clock, the block cuts an 8-bit word out of that history. A rotation amount selects where the cut falls.

A controller checks the frame lane's word against a fixed marker. While the word does not match, the controller steps the rotation and waits a programmable number of words before it checks again. If all eight rotations fail, it also slips the word-forming phase by one nibble. It declares lock after a run of consecutive matches. It drops lock after a run of consecutive mismatches and then searches again. Every data lane uses the rotation chosen on the frame lane, in the same cycle. The aligned sample bytes come out with a valid strobe and a lock flag.

Top module: `frame_aligner`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `locked` and `out_valid` are both 0. The rotation starts at zero.
- R2: Each lane nibble carries the earliest serial bit in bit 3. The block forms one byte per lane every two fabric cycles, with the earliest serial bit in bit 7. While locked, `out_valid` is high on exactly every second cycle.
- R3: The block steps the rotation through all eight values. After each step it waits SETTLE words before comparing again. If all eight values fail, it slips the word phase by one nibble. With a clean frame stream, `locked` rises within 2*(16*(SETTLE+1)+LOCK_N)+8 cycles of reset release, or of clean frames resuming.
- R4: With MARKER_INV=0 the marker is 8'h0F. With MARKER_INV=1 it is 8'hF0. An instance given the inverted frame stream locks and produces the same bytes.
- R5: `locked` rises only after LOCK_N consecutive matching frame words, so never sooner than 2*(LOCK_N-1) cycles after clean frames begin.
- R6: Fewer than UNLOCK_M consecutive mismatching frame words leave `locked` high. UNLOCK_M consecutive mismatches drop it, and the search restarts.
- R7: While locked, every valid output byte on every lane equals the transmitted sample byte. Lane L occupies bits [8L+7:8L], and successive valid outputs carry successive samples.
- R8: `out_valid` is high only while `locked` is high, and never on two consecutive cycles.
- R9: While locked, the rotation is held, so a short burst of corrupted frame words does not disturb the data lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock, one quarter of the lane bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_nib | input | 4 | Frame lane nibble, earliest bit in bit 3 |
| data_nib | input | NLANES*4 | Data lane nibbles, lane L at [4L+3:4L] |
| out_bytes | output | NLANES*8 | Aligned sample bytes, lane L at [8L+7:8L] |
| out_valid | output | 1 | One strobe per aligned sample word while locked |
| locked | output | 1 | Frame marker alignment established |

## Verification
The bench starts the serial stream at a random bit offset between 0 and 11. This covers every rotation and both nibble phases. A design that applied the rotation backwards, or only to the frame lane, would then show shifted data bytes. The bench injects one less than UNLOCK_M corrupted frame bytes and checks that lock survives and the data stays correct. A miss counter that was off by one would drop lock here. A longer burst must drop lock, and the design must lock again no sooner than LOCK_N words and no later than the search bound. A second instance with the inverted marker must lock on the complemented frame stream and produce identical bytes. A design that swapped the two marker values would never lock on that stream.

// File: rtl/frame_align_pkg.sv
`timescale 1ns/1ps
package frame_align_pkg;
    localparam int NIB_W  = 4;
    localparam int WORD_W = 8;
    localparam int ROT_W  = 3;

    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } align_state_e;

    function automatic logic [WORD_W-1:0] marker_of(input bit inv);
        return inv ? 8'hF0 : 8'h0F;
    endfunction
endpackage

// File: rtl/fa_lane_window.sv
`timescale 1ns/1ps
module fa_lane_window
    import frame_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  nib_i,
    input  logic [ROT_W-1:0]  rot_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int HIST_W = 2*WORD_W - NIB_W;
    localparam int SPAN_W = HIST_W + NIB_W;

    logic [HIST_W-1:0] hist_q, hist_d;
    logic [SPAN_W-1:0] span;

    // Higher index = older bit; the window at rot_i spans bits rot_i+7..rot_i.
    always_comb begin
        span   = {hist_q, nib_i};
        hist_d = span[HIST_W-1:0];
        word_o = span[rot_i +: WORD_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end
endmodule

// File: rtl/fa_align_ctrl.sv
`timescale 1ns/1ps
module fa_align_ctrl
    import frame_align_pkg::*;
#(
    parameter int unsigned SETTLE     = 1,
    parameter int unsigned LOCK_N     = 4,
    parameter int unsigned UNLOCK_M   = 8,
    parameter bit          MARKER_INV = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] frame_word_i,
    output logic              strobe_o,
    output logic              word_ok_o,
    output logic [ROT_W-1:0]  rot_o,
    output logic              locked_o
);
    localparam int SW = $clog2(SETTLE + 2);
    localparam int MW = $clog2(LOCK_N + 1);
    localparam int XW = $clog2(UNLOCK_M + 1);
    localparam logic [WORD_W-1:0] MARKER = marker_of(MARKER_INV);

    typedef struct packed {
        align_state_e     st;
        logic             phase;
        logic [ROT_W-1:0] rot;
        logic [SW-1:0]    settle;
        logic [MW-1:0]    hits;
        logic [XW-1:0]    misses;
    } ctrl_s;

    ctrl_s q, d;
    logic  hit;

    always_comb begin
        hit     = (frame_word_i == MARKER);
        d       = q;
        d.phase = ~q.phase;
        if (q.phase) begin
            case (q.st)
                ST_SEARCH: begin
                    if (q.settle != '0) begin
                        d.settle = q.settle - 1'b1;
                    end else if (hit) begin
                        if (q.hits == MW'(LOCK_N - 1)) begin
                            d.st     = ST_LOCKED;
                            d.hits   = '0;
                            d.misses = '0;
                        end else begin
                            d.hits = q.hits + 1'b1;
                        end
                    end else begin
                        d.hits   = '0;
                        d.rot    = q.rot + 1'b1;
                        d.settle = SW'(SETTLE);
                        if (q.rot == '1) d.phase = q.phase; // slip one nibble
                    end
                end
                ST_LOCKED: begin
                    if (hit) begin
                        d.misses = '0;
                    end else if (q.misses == XW'(UNLOCK_M - 1)) begin
                        d.st     = ST_SEARCH;
                        d.misses = '0;
                        d.hits   = '0;
                        d.settle = SW'(SETTLE);
                    end else begin
                        d.misses = q.misses + 1'b1;
                    end
                end
                default: d.st = ST_SEARCH;
            endcase
        end
        strobe_o  = q.phase;
        word_ok_o = q.phase && (d.st == ST_LOCKED);
        rot_o     = q.rot;
        locked_o  = (q.st == ST_LOCKED);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= ST_SEARCH;
            q.phase  <= 1'b0;
            q.rot    <= '0;
            q.settle <= SW'(SETTLE);
            q.hits   <= '0;
            q.misses <= '0;
        end else begin
            q <= d;
        end
    end

    // R5: lock is entered only from a full run of matches
    p_lock_after_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(q.hits) == MW'(LOCK_N - 1));

    // R6: lock is left only after a full run of misses
    p_unlock_after_misses_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked_o) |-> $past(q.misses) == XW'(UNLOCK_M - 1));

    // R9: rotation frozen while locked
    p_rot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && $past(locked_o)) |-> $stable(q.rot));
endmodule

// File: rtl/frame_aligner.sv
`timescale 1ns/1ps
module frame_aligner
    import frame_align_pkg::*;
#(
    parameter int unsigned NLANES     = 9,
    parameter int unsigned SETTLE     = 1,
    parameter int unsigned LOCK_N     = 4,
    parameter int unsigned UNLOCK_M   = 8,
    parameter bit          MARKER_INV = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NIB_W-1:0]         frame_nib,
    input  logic [NLANES*NIB_W-1:0]  data_nib,
    output logic [NLANES*WORD_W-1:0] out_bytes,
    output logic                     out_valid,
    output logic                     locked
);
    localparam int BYTES_W = NLANES * WORD_W;

    typedef struct packed {
        logic [BYTES_W-1:0] bytes;
        logic               valid;
    } out_s;

    out_s               q, d;
    logic [WORD_W-1:0]  frame_word;
    logic [BYTES_W-1:0] lane_words;
    logic               strobe, word_ok, ctrl_locked;
    logic [ROT_W-1:0]   rot;

    fa_align_ctrl #(
        .SETTLE(SETTLE), .LOCK_N(LOCK_N), .UNLOCK_M(UNLOCK_M), .MARKER_INV(MARKER_INV)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_word_i(frame_word),
        .strobe_o(strobe), .word_ok_o(word_ok), .rot_o(rot), .locked_o(ctrl_locked)
    );

    fa_lane_window u_frame_lane (
        .clk(clk), .rst_n(rst_n), .nib_i(frame_nib), .rot_i(rot), .word_o(frame_word)
    );

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        fa_lane_window u_lane (
            .clk(clk), .rst_n(rst_n),
            .nib_i(data_nib[g*NIB_W +: NIB_W]),
            .rot_i(rot),
            .word_o(lane_words[g*WORD_W +: WORD_W])
        );
    end

    always_comb begin
        d       = q;
        d.valid = word_ok;
        if (strobe) d.bytes = lane_words;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_bytes = q.bytes;
    assign out_valid = q.valid;
    assign locked    = ctrl_locked;

    // R8: valid only while locked
    p_valid_needs_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> locked);

    // R2 / R8: at most one valid word per two cycles
    p_valid_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

// File: tb/frame_aligner_tb.sv
`timescale 1ns/1ps
module frame_aligner_tb;
    localparam int NL       = 9;
    localparam int SETTLE   = 1;
    localparam int LOCK_N   = 4;
    localparam int UNLOCK_M = 8;
    localparam int BOUND    = 2*(16*(SETTLE+1)+LOCK_N)+8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] frame_nib = '0;
    logic [3:0] frame_nib_inv;
    logic [NL*4-1:0] data_nib = '0;
    logic [NL*8-1:0] out_bytes, out_bytes_inv;
    logic out_valid, locked, out_valid_inv, locked_inv;

    assign frame_nib_inv = ~frame_nib;

    always #5 clk = ~clk;

    frame_aligner #(.NLANES(NL), .SETTLE(SETTLE), .LOCK_N(LOCK_N), .UNLOCK_M(UNLOCK_M),
                    .MARKER_INV(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_nib(frame_nib), .data_nib(data_nib),
        .out_bytes(out_bytes), .out_valid(out_valid), .locked(locked));

    frame_aligner #(.NLANES(NL), .SETTLE(SETTLE), .LOCK_N(LOCK_N), .UNLOCK_M(UNLOCK_M),
                    .MARKER_INV(1'b1)) u_dut_inv (
        .clk(clk), .rst_n(rst_n), .frame_nib(frame_nib_inv), .data_nib(data_nib),
        .out_bytes(out_bytes_inv), .out_valid(out_valid_inv), .locked(locked_inv));

    bit    lq[NL+1][$];
    int    errors = 0, checks = 0;
    int    k_tx = 0, bad_left = 0, k_exp = 0, cyc = 0, valid_cnt = 0;
    bit    have_k = 0, prev_valid = 0, done = 0;
    string data_tag = "R7";

    function automatic logic [7:0] lane_val(int lane, int k);
        return 8'(k) ^ 8'(lane * 53) ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_sample();
        logic [7:0] fb, b;
        fb = (bad_left > 0) ? 8'hFF : 8'h0F;
        if (bad_left > 0) bad_left--;
        for (int ch = 0; ch <= NL; ch++) begin
            b = (ch == 0) ? fb : lane_val(ch-1, k_tx);
            for (int i = 7; i >= 0; i--) lq[ch].push_back(b[i]);
        end
        k_tx++;
    endtask

    // Monitor outputs and drive the next nibbles, away from the rising edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            if (out_valid) begin
                valid_cnt++;
                chk(!prev_valid, "R8", 1, 0);
                chk(locked, "R8", locked, 1);
                if (!have_k) begin
                    k_exp  = int'(out_bytes[7:0] ^ 8'hA5);
                    have_k = 1;
                end
                for (int l = 0; l < NL; l++)
                    chk(out_bytes[l*8 +: 8] == lane_val(l, k_exp), data_tag,
                        out_bytes[l*8 +: 8], lane_val(l, k_exp));
                k_exp++;
            end
            if (out_valid && out_valid_inv)
                chk(out_bytes_inv == out_bytes, "R4", out_bytes_inv[7:0], out_bytes[7:0]);
        end
        if (!locked) have_k = 0;
        prev_valid = out_valid;
        while (lq[0].size() < 4) push_sample();
        for (int i = 3; i >= 0; i--) frame_nib[i] = lq[0].pop_front();
        for (int l = 0; l < NL; l++)
            for (int i = 3; i >= 0; i--) data_nib[l*4 + i] = lq[l+1].pop_front();
    end

    initial begin
        repeat (20000) @(negedge clk);
        errors++;
        $display("FAIL R3 watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int p, t0, dropped;
        bit rb;
        p = $urandom_range(0, 11);          // random bit offset and nibble phase
        for (int i = 0; i < p; i++) begin
            rb = 1'($urandom);
            for (int ch = 0; ch <= NL; ch++) lq[ch].push_back(rb);
        end
        repeat (5) @(negedge clk);
        chk(!locked && !out_valid, "R1", {locked, out_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!locked && !out_valid, "R1", {locked, out_valid}, 0);

        t0 = cyc;
        while (!locked && (cyc - t0) < BOUND + 10) @(negedge clk);
        chk(locked && (cyc - t0) <= BOUND, "R3", cyc - t0, BOUND);
        chk((cyc - t0) >= 2*(LOCK_N-1), "R5", cyc - t0, 2*(LOCK_N-1));
        repeat (4) @(negedge clk);
        chk(locked_inv, "R4", locked_inv, 1);

        valid_cnt = 0;
        repeat (40) @(negedge clk);
        chk(valid_cnt == 20, "R2", valid_cnt, 20);
        chk(have_k, "R7", have_k, 1);

        // Short corruption burst: lock and alignment must hold
        data_tag = "R9";
        bad_left = UNLOCK_M - 1;
        dropped  = 0;
        repeat (60) begin
            @(negedge clk);
            if (!locked) dropped = 1;
        end
        chk(!dropped, "R6", dropped, 0);
        chk(have_k, "R9", have_k, 1);
        data_tag = "R7";

        // Long corruption burst: lock must drop
        bad_left = 30;
        t0 = cyc;
        while (locked && (cyc - t0) < 100) @(negedge clk);
        chk(!locked, "R6", locked, 0);
        chk(!locked_inv || bad_left > 0, "R4", locked_inv, 0);

        while (bad_left > 0) @(negedge clk);
        while (frame_nib == 4'hF) @(negedge clk);
        t0 = cyc;
        while (!locked && (cyc - t0) < BOUND + 10) @(negedge clk);
        chk(locked && (cyc - t0) <= BOUND, "R3", cyc - t0, BOUND);
        chk((cyc - t0) >= 2*(LOCK_N-1), "R5", cyc - t0, 2*(LOCK_N-1));
        repeat (40) @(negedge clk);
        chk(have_k, "R7", have_k, 1);
        chk(locked_inv, "R4", locked_inv, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule